// File: doc/BRIEF.md
# Ethernet Port Status LED Controller

This block turns the status of a 10/100 Ethernet port into LED drive levels. It takes link state, the line speed, the duplex setting, and single-cycle receive, transmit and collision event pulses. It produces a 4-bit LED output. A select pin chooses between two layouts. The three-lamp layout shows speed, link with activity, and duplex with collision. The four-lamp layout has one lamp per speed, its own activity lamp, and a duplex-with-collision lamp.

The blink rates of 10 Hz and 20 Hz come from an internal prescaler that is sized by the `CLK_HZ` parameter. Each blink is a 50% square wave. Activity and collision events are short, so each one restarts a hold timer of about 100 ms (`CLK_HZ/10` cycles). This makes a single event visible as a blink. A collision hides the activity blink. The output is registered, so every input change appears one clock later. All inputs are plain level or pulse control pins. None of them carries a data stream, so no valid/ready flow control applies.

Top module: `eth_led_ctrl`

## Requirements
- R1: During and right after reset every LED is dark. With the default `ACTIVE_LOW=1`, a 0 on an output bit means lit and a 1 means dark, so the reset value is 4'b1111.
- R2: `four_led_mode=0` selects the three-lamp layout, and bit 3 stays dark in it. `four_led_mode=1` selects the four-lamp layout. A change of the select shows on the output at the next clock edge.
- R3: In the three-lamp layout, bit 0 is lit when the link is up at 100 Mbit/s. It is dark at 10 Mbit/s.
- R4: In the three-lamp layout, bit 1 is steadily lit while the link is up. While the activity hold timer runs, it blinks at 10 Hz instead.
- R5: In the three-lamp layout, bit 2 is steadily lit in full duplex. While the collision hold timer runs, it blinks at 20 Hz.
- R6: In the four-lamp layout, bit 0 is lit only when the link is up at 100 Mbit/s. Bit 1 is lit only when the link is up at 10 Mbit/s. The two are never lit together.
- R7: In the four-lamp layout, bit 2 blinks at 10 Hz while the activity hold timer runs. It is dark otherwise.
- R8: In the four-lamp layout, bit 3 is lit in full duplex. While the collision hold timer runs, it blinks at 20 Hz.
- R9: While the collision hold timer runs, there is no activity blink. In the three-lamp layout, bit 1 stays steadily lit. In the four-lamp layout, bit 2 stays dark.
- R10: With the link down, the link, speed and activity lamps (bits 0 and 1, plus bit 2 in the four-lamp layout) are dark whatever the activity is. The duplex/collision lamp does not depend on the link.
- R11: Each receive, transmit or collision pulse restarts a hold timer of `CLK_HZ/10` cycles. The blink lasts while the timer runs and stops once it expires.
- R12: The 10 Hz blink has a period of `CLK_HZ/10` cycles and the 20 Hz blink a period of `CLK_HZ/20` cycles. Both have a 50% duty cycle. The 10 Hz wave changes state only when the 20 Hz wave falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of `CLK_HZ` Hz |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link is established |
| speed_100 | input | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| full_duplex | input | 1 | Port runs in full duplex |
| rx_act | input | 1 | One-cycle pulse per received frame |
| tx_act | input | 1 | One-cycle pulse per transmitted frame |
| col | input | 1 | One-cycle pulse per collision |
| four_led_mode | input | 1 | 0 = three-lamp layout, 1 = four-lamp layout |
| led_o | output | 4 | LED drive levels, polarity set by `ACTIVE_LOW` |

## Verification
The bench runs with a small clock rate, so that blink periods of 200 and 100 cycles fit into short windows. It counts both the lit cycles and the state changes in each window. This separates a 10 Hz blink from a 20 Hz blink, and it catches a wrong duty cycle or a swapped rate. Suppression is checked by raising collision and activity together. A design that let activity through would show an activity lamp that toggles, or a link lamp that toggles, where the lamp should be dark or steady. A single pulse followed by a long silence exposes a hold timer that never expires or never starts. Link-down runs with activity present catch a design that gates only some of the lamps. A select change checked one clock later catches an extra pipeline stage.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

  localparam int LED_W = 4;

  typedef enum logic {
    SCHEME_3 = 1'b0,
    SCHEME_4 = 1'b1
  } led_scheme_e;

  typedef struct packed {
    logic link;
    logic spd100;
    logic fdx;
  } port_state_t;

endpackage

// File: rtl/eth_led_blink_gen.sv
module eth_led_blink_gen #(
  parameter int CLK_HZ = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic sq10,
  output logic sq20
);

  // half period of the 20 Hz wave in clock cycles
  localparam int HALF20 = (CLK_HZ / 40 < 1) ? 1 : CLK_HZ / 40;
  localparam int CW     = $clog2(HALF20 + 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF20 - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sq20 <= 1'b0;
      sq10 <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sq20 <= ~sq20;
      if (sq20) sq10 <= ~sq10;   // slow wave steps on each falling edge of the fast one
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/eth_led_stretch.sv
module eth_led_stretch #(
  parameter int HOLD_CYC = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (trig)           remain <= HW'(HOLD_CYC);
    else if (remain != '0)   remain <= remain - HW'(1);
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/eth_led_map.sv
module eth_led_map
  import eth_led_pkg::*;
(
  input  led_scheme_e      scheme,
  input  port_state_t      st,
  input  logic             act_busy,
  input  logic             col_busy,
  input  logic             sq10,
  input  logic             sq20,
  output logic [LED_W-1:0] lit
);

  logic act_show;
  logic dpx_lamp;

  // activity only blinks while no collision is being shown
  assign act_show = act_busy & ~col_busy;
  assign dpx_lamp = col_busy ? sq20 : st.fdx;

  always_comb begin
    lit = '0;
    unique case (scheme)
      SCHEME_3: begin
        lit[0] = st.link & st.spd100;
        lit[1] = st.link & (act_show ? sq10 : 1'b1);
        lit[2] = dpx_lamp;
        lit[3] = 1'b0;
      end
      SCHEME_4: begin
        lit[0] = st.link & st.spd100;
        lit[1] = st.link & ~st.spd100;
        lit[2] = st.link & act_show & sq10;
        lit[3] = dpx_lamp;
      end
      default: lit = '0;
    endcase
  end

endmodule

// File: rtl/eth_led_ctrl.sv
module eth_led_ctrl
  import eth_led_pkg::*;
#(
  parameter int CLK_HZ     = 25_000_000,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  input  logic       speed_100,
  input  logic       full_duplex,
  input  logic       rx_act,
  input  logic       tx_act,
  input  logic       col,
  input  logic       four_led_mode,
  output logic [3:0] led_o
);

  localparam int               HOLD_CYC = (CLK_HZ / 10 < 1) ? 1 : CLK_HZ / 10;
  localparam int               N_EV     = 2;
  localparam logic [LED_W-1:0] DARK     = ACTIVE_LOW ? {LED_W{1'b1}} : {LED_W{1'b0}};

  logic [N_EV-1:0]  ev_trig;
  logic [N_EV-1:0]  ev_busy;
  logic             act_busy;
  logic             col_busy;
  logic             sq10;
  logic             sq20;
  logic [LED_W-1:0] lit;
  logic [LED_W-1:0] led_q;
  port_state_t      st;
  led_scheme_e      scheme;

  assign ev_trig = {col, rx_act | tx_act};

  for (genvar g = 0; g < N_EV; g++) begin : g_hold
    eth_led_stretch #(.HOLD_CYC(HOLD_CYC)) i_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (ev_trig[g]),
      .busy (ev_busy[g])
    );
  end

  assign act_busy = ev_busy[0];
  assign col_busy = ev_busy[1];

  eth_led_blink_gen #(.CLK_HZ(CLK_HZ)) i_blink (
    .clk  (clk),
    .rst_n(rst_n),
    .sq10 (sq10),
    .sq20 (sq20)
  );

  assign st.link   = link_up;
  assign st.spd100 = speed_100;
  assign st.fdx    = full_duplex;
  assign scheme    = four_led_mode ? SCHEME_4 : SCHEME_3;

  eth_led_map i_map (
    .scheme  (scheme),
    .st      (st),
    .act_busy(act_busy),
    .col_busy(col_busy),
    .sq10    (sq10),
    .sq20    (sq20),
    .lit     (lit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) led_q <= DARK;
    else        led_q <= lit ^ DARK;
  end

  assign led_o = led_q;

endmodule

// File: rtl/eth_led_ctrl_chk.sv
module eth_led_ctrl_chk #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       link_up,
  input logic       four_led_mode,
  input logic       col,
  input logic [3:0] led_o,
  input logic       col_busy,
  input logic       sq10,
  input logic       sq20
);

  logic [3:0] on;
  assign on = ACTIVE_LOW ? ~led_o : led_o;

  // R2: unused lamp stays dark in the three-lamp layout
  p_unused_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !four_led_mode |=> !on[3]);

  // R6: speed lamps exclusive in the four-lamp layout
  p_speed_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    four_led_mode |=> !(on[0] && on[1]));

  // R9: collision hides activity in both layouts
  p_col_hides_act4_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (four_led_mode && col_busy) |=> !on[2]);
  p_col_hides_act3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!four_led_mode && link_up && col_busy) |=> on[1]);

  // R10: link down darkens link and speed lamps
  p_link_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (!on[0] && !on[1]));
  p_link_down_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && four_led_mode) |=> !on[2]);

  // R11: a collision pulse starts the hold timer at once
  p_hold_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    col |=> col_busy);

  // R12: slow wave moves only on a fall of the fast wave
  p_slow_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sq10 != $past(sq10)) |-> $fell(sq20));

endmodule

bind eth_led_ctrl eth_led_ctrl_chk #(.ACTIVE_LOW(ACTIVE_LOW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_up      (link_up),
  .four_led_mode(four_led_mode),
  .col          (col),
  .led_o        (led_o),
  .col_busy     (col_busy),
  .sq10         (sq10),
  .sq20         (sq20)
);

// File: tb/test_eth_led_ctrl.sv
module test_eth_led_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2000;          // 10 Hz -> 200 cycles, 20 Hz -> 100 cycles
  localparam int HOLD       = CLK_HZ / 10;   // 200 cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_up = 1'b0;
  logic       speed_100 = 1'b0;
  logic       full_duplex = 1'b0;
  logic       rx_act = 1'b0;
  logic       tx_act = 1'b0;
  logic       col = 1'b0;
  logic       four_led_mode = 1'b0;
  logic [3:0] led_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eth_led_ctrl #(.CLK_HZ(CLK_HZ), .ACTIVE_LOW(1'b1)) i_eth_led_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_up      (link_up),
    .speed_100    (speed_100),
    .full_duplex  (full_duplex),
    .rx_act       (rx_act),
    .tx_act       (tx_act),
    .col          (col),
    .four_led_mode(four_led_mode),
    .led_o        (led_o)
  );

  task automatic chk_vec(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: led_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_vec++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic set_state(input logic lk, input logic s100, input logic fd, input logic m4);
    @(negedge clk);
    link_up = lk; speed_100 = s100; full_duplex = fd; four_led_mode = m4;
  endtask

  // samples n negedges; the selected bit's lit count and state changes
  task automatic run_win(input int n, input int bitn, input bit do_act, input bit do_col,
                         output int lit_cnt, output int edges);
    logic prev, cur;
    lit_cnt = 0; edges = 0; prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = ~led_o[bitn];
      if (cur) lit_cnt++;
      if (i > 0 && cur != prev) edges++;
      prev = cur;
      tx_act = do_act && (i % 100 == 0);
      col    = do_col && (i % 100 == 0);
    end
    @(negedge clk);
    tx_act = 1'b0; col = 1'b0;
  endtask

  task automatic prime(input bit a, input bit c);
    @(negedge clk); tx_act = a; col = c;
    @(negedge clk); tx_act = 1'b0; col = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic quiet();
    repeat (HOLD + 10) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_vec("R1 during reset", led_o, 4'b1111);
    rst_n = 1'b1;
    @(negedge clk);
    chk_vec("R1 after reset", led_o, 4'b1111);
  endtask

  task automatic t_three_static();
    set_state(1, 1, 1, 0);
    @(negedge clk);
    chk_vec("R3 R4 R5 R2 3-lamp 100/FD", led_o, 4'b1000);
    set_state(1, 0, 0, 0);
    @(negedge clk);
    chk_vec("R3 R4 3-lamp 10/HD", led_o, 4'b1101);
  endtask

  task automatic t_four_static();
    set_state(1, 1, 0, 1);
    @(negedge clk);
    chk_vec("R6 4-lamp 100/HD", led_o, 4'b1110);
    set_state(1, 0, 1, 1);
    @(negedge clk);
    chk_vec("R6 R8 4-lamp 10/FD", led_o, 4'b0101);
  endtask

  task automatic t_mode_switch();
    set_state(1, 1, 1, 0);
    @(negedge clk);
    chk_vec("R2 before switch", led_o, 4'b1000);
    @(negedge clk);
    four_led_mode = 1'b1;
    @(negedge clk);
    chk_vec("R2 switch next clock", led_o, 4'b0110);
  endtask

  task automatic t_link_down();
    int l, e;
    set_state(0, 1, 1, 1);
    prime(1, 0);
    run_win(400, 0, 1, 0, l, e); chk_rng("R10 4-lamp bit0 dark", l, 0, 0);
    run_win(400, 1, 1, 0, l, e); chk_rng("R10 4-lamp bit1 dark", l, 0, 0);
    run_win(400, 2, 1, 0, l, e); chk_rng("R10 4-lamp activity dark", l, 0, 0);
    run_win(400, 3, 1, 0, l, e); chk_rng("R10 duplex lamp unaffected", l, 400, 400);
    set_state(0, 1, 1, 0);
    run_win(400, 1, 1, 0, l, e); chk_rng("R10 3-lamp link dark", l, 0, 0);
    quiet();
  endtask

  task automatic t_act_blink();
    int l, e;
    set_state(1, 1, 0, 1);
    prime(1, 0);
    run_win(400, 2, 1, 0, l, e);
    chk_rng("R7 R12 4-lamp activity duty", l, 200, 200);
    chk_rng("R7 R12 4-lamp activity 10 Hz edges", e, 3, 4);
    set_state(1, 1, 0, 0);
    run_win(400, 1, 1, 0, l, e);
    chk_rng("R4 3-lamp link blink duty", l, 200, 200);
    chk_rng("R4 3-lamp link blink 10 Hz edges", e, 3, 4);
    quiet();
  endtask

  task automatic t_collision();
    int l, e;
    set_state(1, 1, 1, 1);
    prime(1, 1);
    run_win(400, 2, 1, 1, l, e);
    chk_rng("R9 4-lamp activity hidden", l, 0, 0);
    run_win(400, 3, 1, 1, l, e);
    chk_rng("R8 R12 collision duty", l, 200, 200);
    chk_rng("R8 R12 collision 20 Hz edges", e, 7, 8);
    set_state(1, 1, 1, 0);
    run_win(400, 1, 1, 1, l, e);
    chk_rng("R9 3-lamp link steady", l, 400, 400);
    run_win(400, 2, 1, 1, l, e);
    chk_rng("R5 3-lamp collision duty", l, 200, 200);
    chk_rng("R5 3-lamp collision 20 Hz edges", e, 7, 8);
    quiet();
  endtask

  task automatic t_hold();
    int l, e;
    set_state(1, 1, 0, 1);
    @(negedge clk); rx_act = 1'b1;
    @(negedge clk); rx_act = 1'b0;
    run_win(190, 2, 0, 0, l, e);
    chk_rng("R11 single pulse visible", l, 90, 100);
    repeat (20) @(negedge clk);
    run_win(100, 2, 0, 0, l, e);
    chk_rng("R11 blink stops after hold", l, 0, 0);
    set_state(1, 1, 1, 0);
    @(negedge clk); col = 1'b1;
    @(negedge clk); col = 1'b0;
    quiet();
    run_win(100, 2, 0, 0, l, e);
    chk_rng("R11 duplex steady after collision hold", l, 100, 100);
  endtask

  initial begin
    t_reset();
    t_three_static();
    t_four_static();
    t_mode_switch();
    t_link_down();
    t_act_blink();
    t_collision();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule